// File: doc/BRIEF.md
# Byte-Mask Flow Tag Generator

This block derives a 32-bit flow tag from the opening bytes of a packet that arrives one byte per clock. Which bytes contribute is decided by a programmable bitmap with one bit per byte offset. The block holds several such bitmaps, and the caller picks one for each packet at start of packet, together with a tag-mode flag and a fallback tag. Selected bytes are folded, most significant bit first, into a CRC-32 with generator 0x04C11DB7 and an all-ones start value. No reflection and no final inversion are applied. The resulting remainder is the tag.

The bitmaps are held in byte-wide registers behind a write-only configuration port. A write either replaces a register or ORs new enable bits into it. The OR form lets software build a mask field by field. To clear a mask, write zero to each of its registers with the replace form. The mask, mode and fallback tag are captured when a packet starts, so reprogramming never disturbs a packet that is already in flight.

Top module: `flow_tag_gen`

## Requirements
- R1: With `cfg_we` high and `cfg_merge` low, the addressed mask register takes `cfg_wdata` outright at that clock edge. Registers that are not addressed keep their contents.
- R2: With `cfg_we` high and `cfg_merge` high, the addressed register becomes its old contents ORed with `cfg_wdata`. Bits already set are never cleared.
- R3: Byte offset X of mask M is enabled by register address M*16 + X/8, bit 7 - (X mod 8). The most significant bit is offset 0 of that group of eight. Offsets 0 to 127 are covered.
- R4: With tag mode 1, the tag is the CRC-32 (generator 0x04C11DB7, start 0xFFFFFFFF, each byte MSB first, no final XOR) over the enabled bytes in offset order. If no byte is enabled, the tag is 0xFFFFFFFF.
- R5: With tag mode 0 at start of packet, the tag equals `in_default_tag` as it was sampled with the first byte, whatever the mask contents.
- R6: `tag_valid` is high for exactly the one cycle after the clock edge that accepts either the byte at offset 127 or the byte marked `in_eop`, whichever comes first.
- R7: Bytes past offset 127, bytes after end of packet and valid bytes outside a packet (before the next `in_sop`) have no effect and raise no `tag_valid`.
- R8: The mask, mode and fallback tag are sampled with the `in_sop` byte. A mask write on that same edge or later within the packet affects only later packets.
- R9: An `in_sop` byte arriving while a packet is still open abandons that packet without a tag and starts a new one at offset 0.
- R10: After reset, `tag_valid` and `tag` are 0 and every mask register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_addr | input | 6 | Mask register address, mask*16 + group |
| cfg_wdata | input | 8 | Enable bits to write |
| cfg_merge | input | 1 | 1: OR into register, 0: replace |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Byte is offset 0 of a packet |
| in_eop | input | 1 | Byte is the last of the packet |
| in_data | input | 8 | Packet byte |
| in_mask_sel | input | 2 | Mask used by this packet, sampled with in_sop |
| in_tag_mode | input | 1 | 1: masked CRC tag, 0: fallback tag; sampled with in_sop |
| in_default_tag | input | 32 | Fallback tag, sampled with in_sop |
| tag_valid | output | 1 | One-cycle strobe for the tag |
| tag | output | 32 | Flow tag, held until the next tag |

## Verification
Each tag is due in the cycle right after the edge that accepts the closing byte, which is offset 127 or the end-of-packet byte. No other register lies on that path. The bench drives every byte on a falling edge and reads the outputs on the next falling edge. Each such read is therefore the result of exactly the byte driven one step earlier, and every byte position is checked for the presence or absence of `tag_valid`. A mask write takes effect at its own clock edge, so tags that depend on it are checked from the packet that starts after that write.

// File: rtl/flowtag_pkg.sv
package flowtag_pkg;
   typedef enum logic {
      WR_REPLACE = 1'b0,
      WR_MERGE   = 1'b1
   } wr_mode_e;

   localparam int unsigned BITS_PER_REG = 8;
endpackage

// File: rtl/flowtag_mask_bank.sv
module flowtag_mask_bank
   import flowtag_pkg::*;
#(
   parameter int unsigned NUM_MASKS     = 4,
   parameter int unsigned REGS_PER_MASK = 16,
   localparam int unsigned TOTAL_REGS   = NUM_MASKS * REGS_PER_MASK,
   localparam int unsigned ADDR_W       = (TOTAL_REGS > 1) ? $clog2(TOTAL_REGS) : 1,
   localparam int unsigned SPAN         = REGS_PER_MASK * BITS_PER_REG
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [BITS_PER_REG-1:0]       wr_data,
   input  logic                          wr_merge,
   output logic [NUM_MASKS*SPAN-1:0]     masks_flat
);
   logic [BITS_PER_REG-1:0] regs [TOTAL_REGS];
   logic [BITS_PER_REG-1:0] cur_word;
   wr_mode_e                mode;

   assign mode     = wr_mode_e'(wr_merge);
   assign cur_word = regs[wr_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL_REGS; i++) regs[i] <= '0;
      end else if (wr_en) begin
         if (mode == WR_MERGE) regs[wr_addr] <= cur_word | wr_data;
         else                  regs[wr_addr] <= wr_data;
      end
   end

   // offset x of mask m: register m*R + x/8, bit 7 - x%8 (first offset on the MSB)
   for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
      for (genvar x = 0; x < SPAN; x++) begin : g_off
         assign masks_flat[m*SPAN + x] =
            regs[m*REGS_PER_MASK + x/BITS_PER_REG][BITS_PER_REG-1-(x%BITS_PER_REG)];
      end
   end

   assert_hold_without_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(masks_flat));

   assert_merge_keeps_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_merge) |=> ((regs[$past(wr_addr)] & $past(cur_word)) == $past(cur_word)));
endmodule

// File: rtl/flowtag_crc_step.sv
module flowtag_crc_step #(
   parameter int unsigned    TAG_W = 32,
   parameter logic [TAG_W-1:0] POLY = 32'h04C11DB7
) (
   input  logic [TAG_W-1:0] crc_in,
   input  logic [7:0]       data,
   output logic [TAG_W-1:0] crc_out
);
   logic [TAG_W-1:0] stage [9];

   assign stage[0] = crc_in;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb = stage[b][TAG_W-1] ^ data[7-b];
      assign stage[b+1] = {stage[b][TAG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[8];
endmodule

// File: rtl/flow_tag_gen.sv
module flow_tag_gen
   import flowtag_pkg::*;
#(
   parameter int unsigned      NUM_MASKS     = 4,
   parameter int unsigned      REGS_PER_MASK = 16,
   parameter int unsigned      TAG_W         = 32,
   parameter logic [TAG_W-1:0] POLY          = 32'h04C11DB7,
   parameter logic [TAG_W-1:0] SEED          = '1,
   localparam int unsigned TOTAL_REGS = NUM_MASKS * REGS_PER_MASK,
   localparam int unsigned ADDR_W     = (TOTAL_REGS > 1) ? $clog2(TOTAL_REGS) : 1,
   localparam int unsigned SEL_W      = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1,
   localparam int unsigned SPAN       = REGS_PER_MASK * BITS_PER_REG,
   localparam int unsigned OFF_W      = $clog2(SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              cfg_merge,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [7:0]        in_data,
   input  logic [SEL_W-1:0]  in_mask_sel,
   input  logic              in_tag_mode,
   input  logic [TAG_W-1:0]  in_default_tag,
   output logic              tag_valid,
   output logic [TAG_W-1:0]  tag
);
   // elaboration-time parameter checks
   if (TAG_W < 8) begin : g_bad_width
      $error("TAG_W must be at least 8");
   end
   if (NUM_MASKS < 1) begin : g_bad_count
      $error("NUM_MASKS must be at least 1");
   end
   if ((REGS_PER_MASK & (REGS_PER_MASK - 1)) != 0 || REGS_PER_MASK < 1) begin : g_bad_regs
      $error("REGS_PER_MASK must be a power of two");
   end
   if ((NUM_MASKS & (NUM_MASKS - 1)) != 0) begin : g_bad_masks
      $error("NUM_MASKS must be a power of two");
   end

   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SPAN - 1);

   logic [NUM_MASKS*SPAN-1:0] masks_flat;
   logic [SPAN-1:0]           live_mask, snap_mask, mask_eff;
   logic                      active, mode_q, mode_eff, take, last_byte, use_byte;
   logic [OFF_W-1:0]          cnt, off;
   logic [TAG_W-1:0]          crc_q, crc_base, crc_fold, crc_next;
   logic [TAG_W-1:0]          dflt_q, dflt_eff;

   flowtag_mask_bank #(
      .NUM_MASKS     (NUM_MASKS),
      .REGS_PER_MASK (REGS_PER_MASK)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_addr    (cfg_addr),
      .wr_data    (cfg_wdata),
      .wr_merge   (cfg_merge),
      .masks_flat (masks_flat)
   );

   flowtag_crc_step #(
      .TAG_W (TAG_W),
      .POLY  (POLY)
   ) u_crc (
      .crc_in  (crc_base),
      .data    (in_data),
      .crc_out (crc_fold)
   );

   assign live_mask = masks_flat[in_mask_sel*SPAN +: SPAN];
   assign mask_eff  = in_sop ? live_mask      : snap_mask;
   assign mode_eff  = in_sop ? in_tag_mode    : mode_q;
   assign dflt_eff  = in_sop ? in_default_tag : dflt_q;
   assign off       = in_sop ? '0             : cnt;
   assign crc_base  = in_sop ? SEED           : crc_q;
   assign take      = in_valid && (in_sop || active);
   assign use_byte  = mode_eff && mask_eff[off];
   assign crc_next  = use_byte ? crc_fold : crc_base;
   assign last_byte = in_eop || (off == LAST_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         cnt       <= '0;
         crc_q     <= '0;
         snap_mask <= '0;
         mode_q    <= 1'b0;
         dflt_q    <= '0;
         tag_valid <= 1'b0;
         tag       <= '0;
      end else begin
         tag_valid <= 1'b0;
         if (in_valid && in_sop) begin
            snap_mask <= live_mask;
            mode_q    <= in_tag_mode;
            dflt_q    <= in_default_tag;
         end
         if (take) begin
            crc_q <= crc_next;
            if (last_byte) begin
               active    <= 1'b0;
               cnt       <= '0;
               tag_valid <= 1'b1;
               tag       <= mode_eff ? crc_next : dflt_eff;
            end else begin
               active <= 1'b1;
               cnt    <= off + 1'b1;
            end
         end
      end
   end

   assert_tag_follows_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |-> $past(in_valid));

   assert_no_tag_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !(in_valid && in_sop)) |=> !tag_valid);

   assert_fallback_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_byte && !mode_eff) |=> (tag == $past(dflt_eff)));

   assert_open_packet_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt != '0));
endmodule

// File: tb/tb_flow_tag_gen.sv
module tb_flow_tag_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        cfg_merge = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0]  in_data = '0;
   logic [1:0]  in_mask_sel = '0;
   logic        in_tag_mode = 1'b0;
   logic [31:0] in_default_tag = '0;
   logic        tag_valid;
   logic [31:0] tag;

   int vectors = 0;
   int miscompares = 0;
   logic [7:0] mdl [64];
   logic [7:0] pkt [256];

   always #5 clk = ~clk;

   flow_tag_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_merge(cfg_merge), .in_valid(in_valid),
      .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .in_mask_sel(in_mask_sel), .in_tag_mode(in_tag_mode),
      .in_default_tag(in_default_tag), .tag_valid(tag_valid), .tag(tag)
   );

   function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] d);
      logic [31:0] r = c;
      for (int b = 7; b >= 0; b--) begin
         logic top = r[31] ^ d[b];
         r = r << 1;
         if (top) r = r ^ 32'h04C11DB7;
      end
      return r;
   endfunction

   function automatic logic [31:0] expect_tag(int len, int sel, bit mode, logic [31:0] dflt);
      logic [31:0] c = 32'hFFFFFFFF;
      int lim = (len < 128) ? len : 128;
      if (!mode) return dflt;
      for (int x = 0; x < lim; x++)
         if (mdl[sel*16 + x/8][7 - (x%8)]) c = crc_byte(c, pkt[x]);
      return c;
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic fill(int seed);
      for (int i = 0; i < 256; i++) pkt[i] = 8'((i * 37 + seed * 11 + (i >> 3)) & 8'hFF);
   endtask

   task automatic cfg_write(int addr, logic [7:0] data, bit merge);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data; cfg_merge = merge;
      mdl[addr] = merge ? (mdl[addr] | data) : data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // wr_at: byte index at which a mask write is issued alongside the byte (-1 for none)
   task automatic send_pkt(int len, bit with_eop, int sel, bit mode, logic [31:0] dflt,
                           int wr_at, int wr_addr, logic [7:0] wr_data, string req);
      logic [31:0] exp = expect_tag(len, sel, mode, dflt);
      int last = (len >= 128) ? 127 : (with_eop ? len - 1 : -1);
      for (int i = 0; i <= len; i++) begin
         @(negedge clk);
         if (i > 0) begin
            bit ev = ((i - 1) == last);
            check(tag_valid === ev, req, $sformatf("tag_valid after byte %0d", i - 1),
                  32'(tag_valid), 32'(ev));
            if (ev) check(tag === exp, req, "tag value", tag, exp);
         end
         cfg_we = 1'b0;
         if (i < len) begin
            in_valid = 1'b1; in_sop = (i == 0); in_eop = with_eop && (i == len - 1);
            in_data = pkt[i];
            in_mask_sel = (i == 0) ? 2'(sel) : 2'(3 - sel);
            in_tag_mode = (i == 0) ? mode : !mode;
            in_default_tag = (i == 0) ? dflt : ~dflt;
            if (i == wr_at) begin
               cfg_we = 1'b1; cfg_addr = 6'(wr_addr); cfg_wdata = wr_data; cfg_merge = 1'b0;
               mdl[wr_addr] = wr_data;
            end
         end else begin
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
         end
      end
      @(negedge clk);
      check(tag_valid === 1'b0, req, "tag_valid after packet", 32'(tag_valid), 32'h0);
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      check(tag_valid === 1'b0, "R10", "reset tag_valid", 32'(tag_valid), 32'h0);
      check(tag === 32'h0, "R10", "reset tag", tag, 32'h0);
      rst_n = 1'b1;

      // R10 / R4: empty masks give the seed
      fill(1);
      send_pkt(40, 1, 0, 1, 32'h12345678, -1, 0, 0, "R10");
      check(expect_tag(40, 0, 1, 0) === 32'hFFFFFFFF, "R4", "empty mask model", expect_tag(40, 0, 1, 0), 32'hFFFFFFFF);

      // R3: sweep every single offset of mask 1
      for (int x = 0; x < 128; x++) begin
         fill(x);
         cfg_write(16 + x/8, 8'h80 >> (x % 8), 1'b1);
         send_pkt(128, 1, 1, 1, 32'h0, -1, 0, 0, "R3");
         check(expect_tag(128, 1, 1, 0) === crc_byte(32'hFFFFFFFF, pkt[x]), "R3",
               "single-offset model", expect_tag(128, 1, 1, 0), crc_byte(32'hFFFFFFFF, pkt[x]));
         cfg_write(16 + x/8, 8'h00, 1'b0);
      end

      // R2: merge builds fields; R1: replace overwrites
      fill(200);
      cfg_write(32, 8'h81, 1'b0);
      cfg_write(32, 8'h18, 1'b1);
      send_pkt(20, 1, 2, 1, 32'h0, -1, 0, 0, "R2");
      cfg_write(32, 8'h01, 1'b0);
      send_pkt(20, 1, 2, 1, 32'h0, -1, 0, 0, "R1");

      // R5: fallback tag with a populated mask
      send_pkt(30, 1, 2, 0, 32'hCAFEF00D, -1, 0, 0, "R5");

      // R4: full mask 3 over a long packet; R7: bytes past 127 ignored
      for (int r = 0; r < 16; r++) cfg_write(48 + r, 8'hFF, 1'b0);
      fill(77);
      send_pkt(200, 1, 3, 1, 32'h0, -1, 0, 0, "R7");
      send_pkt(128, 0, 3, 1, 32'h0, -1, 0, 0, "R4");

      // R6: short packet ends at eop; mask bit beyond the end is ignored
      cfg_write(0, 8'h20, 1'b0);
      cfg_write(6, 8'h20, 1'b0);
      fill(9);
      send_pkt(10, 1, 0, 1, 32'h0, -1, 0, 0, "R6");
      send_pkt(1, 1, 0, 1, 32'h0, -1, 0, 0, "R6");

      // R7: stray bytes outside a packet
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i > 0) check(tag_valid === 1'b0, "R7", "stray byte", 32'(tag_valid), 32'h0);
         in_valid = (i < 5); in_sop = 1'b0; in_eop = (i == 2); in_data = 8'h5A;
      end

      // R8: writes on the sop edge and mid-packet reach only later packets
      for (int r = 0; r < 16; r++) cfg_write(r, 8'h00, 1'b0);
      fill(3);
      send_pkt(128, 1, 0, 1, 32'h0, 0, 0, 8'hFF, "R8");
      send_pkt(128, 1, 0, 1, 32'h0, 60, 15, 8'hF0, "R8");
      send_pkt(128, 1, 0, 1, 32'h0, -1, 0, 0, "R8");

      // R9: unfinished packet abandoned by a new start
      fill(5);
      send_pkt(7, 0, 0, 1, 32'h0, -1, 0, 0, "R9");
      fill(6);
      send_pkt(25, 1, 0, 1, 32'h0, -1, 0, 0, "R9");

      // R3: each mask index selects its own bank
      for (int s = 0; s < 4; s++) for (int r = 0; r < 16; r++)
         cfg_write(s*16 + r, 8'((s + 1) * 8'h11 ^ r), 1'b0);
      for (int s = 0; s < 4; s++) begin
         fill(40 + s);
         send_pkt(128, 1, s, 1, 32'h0, -1, 0, 0, "R3");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule